// File: doc/BRIEF.md
# Multi-Cycle Instruction Sequencer

This block is the control state machine for a processor datapath that is not pipelined. Each instruction runs over several clock cycles. The sequencer fetches it, decodes it and executes it. It then adds a data-memory access or a register write-back if the instruction's class needs one. In each cycle it raises exactly one enable strobe toward the datapath. It also raises a program-counter update strobe in the last cycle of every instruction.

An upstream decoder supplies the instruction class, and the sequencer samples it at the end of the decode cycle. Branches and no-ops leave the sequence early, so an instruction takes 2, 3, 4 or 5 cycles. Two free-running counters, one for elapsed cycles and one for retired instructions, let the average cycles per instruction of a program mix be read directly.

Top module: `mc_sequencer`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, the fetch strobe `imem_rd` is the only active strobe, and both counters read zero.
- R2: A cycle with `imem_rd` high is always followed by a decode cycle with `rf_rd` high.
- R3: Class code 0 (no-op) takes 2 cycles: fetch, then decode with `pc_upd` high. Codes 5, 6 and 7 are treated as code 0.
- R4: Class code 1 (branch or jump) takes 3 cycles: fetch, decode, then execute (`alu_en`) with `pc_upd` high.
- R5: Class code 2 (ALU operation) takes 4 cycles: fetch, decode, execute, then write-back (`rf_wr`) with `pc_upd` high.
- R6: Class code 4 (store) takes 4 cycles: fetch, decode, execute, then data write (`dmem_wr`) with `pc_upd` high.
- R7: Class code 3 (load) takes 5 cycles: fetch, decode, execute, data read (`dmem_rd`), then write-back (`rf_wr`) with `pc_upd` high.
- R8: In every cycle exactly one of `imem_rd`, `rf_rd`, `alu_en`, `dmem_rd`, `dmem_wr` and `rf_wr` is high. `pc_upd` is high only in an instruction's last cycle, and the cycle after it is a fetch.
- R9: `insn_class` is sampled only at the clock edge that ends the decode cycle. Its value in every other cycle has no effect on the strobes.
- R10: `cycle_cnt` increases by one on every clock edge out of reset. `retired_cnt` increases by one exactly at the edge that ends a cycle in which `pc_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_class | input | 3 | Decoded instruction class, valid during the decode cycle |
| imem_rd | output | 1 | Instruction-memory read enable (fetch) |
| rf_rd | output | 1 | Register-file read enable (decode) |
| alu_en | output | 1 | ALU enable (execute) |
| dmem_rd | output | 1 | Data-memory read enable |
| dmem_wr | output | 1 | Data-memory write enable |
| rf_wr | output | 1 | Register-file write enable |
| pc_upd | output | 1 | Program-counter update, last cycle of each instruction |
| cycle_cnt | output | CNT_W | Cycles elapsed since reset |
| retired_cnt | output | CNT_W | Instructions completed since reset |

## Verification
The assertions assume that `insn_class` carries a settled value at the edge that ends decode. They place no other demand on that input, because every other cycle ignores it. The stimulus changes the class only away from clock edges, and it holds the real class only during decode. In the other cycles it deliberately drives a different code, so that any sampling outside decode would show up as a wrong strobe sequence. The counter assertions assume the counters do not wrap within a run, and the runs stay far below the counter range.

// File: rtl/mc_sequencer.sv
module mc_sequencer #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       insn_class,
  output logic             imem_rd,
  output logic             rf_rd,
  output logic             alu_en,
  output logic             dmem_rd,
  output logic             dmem_wr,
  output logic             rf_wr,
  output logic             pc_upd,
  output logic [CNT_W-1:0] cycle_cnt,
  output logic [CNT_W-1:0] retired_cnt
);

  localparam logic [2:0] C_NOP = 3'd0, C_BRJ = 3'd1, C_ALU = 3'd2,
                         C_LD  = 3'd3, C_ST  = 3'd4;

  typedef enum logic [2:0] {
    S_FETCH, S_DECODE, S_EXEC, S_MRD, S_MWR, S_WB
  } state_t;

  state_t     st, st_nx;
  logic [2:0] cls_q;

  assign imem_rd = (st == S_FETCH);
  assign rf_rd   = (st == S_DECODE);
  assign alu_en  = (st == S_EXEC);
  assign dmem_rd = (st == S_MRD);
  assign dmem_wr = (st == S_MWR);
  assign rf_wr   = (st == S_WB);
  assign pc_upd  = (st_nx == S_FETCH);

  always_comb begin
    st_nx = st;
    unique case (st)
      S_FETCH:  st_nx = S_DECODE;
      S_DECODE: begin
        if (insn_class == C_BRJ || insn_class == C_ALU ||
            insn_class == C_LD  || insn_class == C_ST)
          st_nx = S_EXEC;
        else
          st_nx = S_FETCH;
      end
      S_EXEC: begin
        case (cls_q)
          C_ALU:   st_nx = S_WB;
          C_LD:    st_nx = S_MRD;
          C_ST:    st_nx = S_MWR;
          default: st_nx = S_FETCH;
        endcase
      end
      S_MRD:    st_nx = S_WB;
      S_MWR:    st_nx = S_FETCH;
      S_WB:     st_nx = S_FETCH;
      default:  st_nx = S_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_FETCH;
      cls_q       <= C_NOP;
      cycle_cnt   <= '0;
      retired_cnt <= '0;
    end else begin
      st        <= st_nx;
      cycle_cnt <= cycle_cnt + 1'b1;
      if (st == S_DECODE) cls_q <= insn_class;
      if (pc_upd) retired_cnt <= retired_cnt + 1'b1;
    end
  end

  p_one_strobe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({imem_rd, rf_rd, alu_en, dmem_rd, dmem_wr, rf_wr}) == 1);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_upd |=> imem_rd);

  p_fetch_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> rf_rd);

  p_exec_from_decode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    alu_en |-> $past(rf_rd));

  p_wb_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rf_wr |-> pc_upd);

  p_store_ends_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_wr |-> pc_upd);

  p_load_wb_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_rd |=> rf_wr);

  p_retire_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    pc_upd |=> retired_cnt == $past(retired_cnt) + 1'b1);

  p_retire_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_upd |=> $stable(retired_cnt));

  p_cycle_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_cnt != '1 |=> cycle_cnt == $past(cycle_cnt) + 1'b1);

endmodule

// File: tb/mc_sequencer_test.sv
`timescale 1ns/1ps
module mc_sequencer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  insn_class = 3'd0;
  logic        imem_rd, rf_rd, alu_en, dmem_rd, dmem_wr, rf_wr, pc_upd;
  logic [31:0] cycle_cnt, retired_cnt;

  int checks = 0;
  int fails  = 0;
  logic [6:0] expq[$];
  int exp_cyc = 0;
  int exp_ret = 0;

  always #2 clk = ~clk;

  mc_sequencer #(.CNT_W(32)) uut (
    .clk(clk), .rst_n(rst_n), .insn_class(insn_class),
    .imem_rd(imem_rd), .rf_rd(rf_rd), .alu_en(alu_en), .dmem_rd(dmem_rd),
    .dmem_wr(dmem_wr), .rf_wr(rf_wr), .pc_upd(pc_upd),
    .cycle_cnt(cycle_cnt), .retired_cnt(retired_cnt)
  );

  function automatic logic [6:0] strobes();
    return {pc_upd, rf_wr, dmem_wr, dmem_rd, alu_en, rf_rd, imem_rd};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // Vector order: {pc_upd, rf_wr, dmem_wr, dmem_rd, alu_en, rf_rd, imem_rd}
  task automatic issue(input logic [2:0] cls, input logic [2:0] junk);
    logic [6:0] seq[$];
    seq.push_back(7'b0000001);
    case (cls)
      3'd1: begin seq.push_back(7'b0000010); seq.push_back(7'b1000100); end
      3'd2: begin seq.push_back(7'b0000010); seq.push_back(7'b0000100);
                  seq.push_back(7'b1100000); end
      3'd3: begin seq.push_back(7'b0000010); seq.push_back(7'b0000100);
                  seq.push_back(7'b0001000); seq.push_back(7'b1100000); end
      3'd4: begin seq.push_back(7'b0000010); seq.push_back(7'b0000100);
                  seq.push_back(7'b1010000); end
      default: seq.push_back(7'b1000010);
    endcase
    foreach (seq[k]) begin
      insn_class = (k == 1) ? cls : junk;
      expq.push_back(seq[k]);
      @(negedge clk);
    end
  endtask

  // Monitor: pops expected strobes, tracks cycle and retire counts on its own
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (expq.size() > 0) begin
        logic [6:0] e;
        e = expq.pop_front();
        check("R3-R8 strobe pattern", {25'd0, strobes()}, {25'd0, e});
        check("R10 cycle counter", cycle_cnt, exp_cyc);
        check("R10 retired counter", retired_cnt, exp_ret);
        exp_cyc++;
        if (e[6]) exp_ret++;
      end
    end
  end

  initial begin
    #40000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] c0, r0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset strobes", {25'd0, strobes()}, 32'd1);
    check("R1 reset cycle count", cycle_cnt, 0);
    check("R1 reset retired count", retired_cnt, 0);
    rst_n = 1'b1;
    // R2/R3/R4/R5/R6/R7 single classes, junk off-decode covers R9
    issue(3'd0, 3'd3);
    issue(3'd1, 3'd4);
    issue(3'd2, 3'd3);
    issue(3'd4, 3'd0);
    issue(3'd3, 3'd1);
    issue(3'd6, 3'd2);   // R3 unused code acts as no-op
    issue(3'd7, 3'd4);
    issue(3'd5, 3'd3);
    issue(3'd3, 3'd0);   // R7 back to back loads
    issue(3'd3, 3'd2);
    issue(3'd2, 3'd1);   // R9 junk is a short-path code
    // CPI mix: 4 loads, 3 stores, 4 branches, 9 ALU ops -> 80 cycles
    #1;
    c0 = cycle_cnt;
    r0 = retired_cnt;
    for (int i = 0; i < 20; i++) begin
      logic [2:0] c;
      if (i % 5 == 0) c = 3'd3;
      else if (i % 5 == 1) c = (i < 15) ? 3'd4 : 3'd2;
      else if (i % 5 == 2) c = 3'd1;
      else c = 3'd2;
      issue(c, 3'd0);
    end
    #1;
    check("R10 mix cycles (CPI 4)", cycle_cnt - c0, 80);
    check("R10 mix retired", retired_cnt - r0, 20);
    check("R8 fetch follows last insn", {25'd0, strobes()}, 32'd1);
    @(negedge clk);
    #2;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule